// File: doc/BRIEF.md
# Cross-Trigger Matrix with Key Lock

This block links event lines from different parts of a chip through a small set of shared broadcast channels. Each input trigger can be connected to any group of channels. Each output trigger can listen to any group of channels. A channel is active in a cycle when at least one input connected to it is high. An output trigger sets when any channel it listens to is active, and it stays set until software clears it. This lets any output act as a level interrupt.

Software reaches the block through a simple 32-bit register bus: an address, a write strobe, write data, and combinational read data. The lock starts closed. Register writes have no effect until one specific 32-bit key is written to the lock-access word. Writing any other value to that word closes the lock again. Reads work in both lock states.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset, the lock is closed and routing is disabled. Every mapping register reads 0 and every output trigger is low.
- R2: A write of 0xC5ACCE55 to offset 0xFB0 opens the lock, and a write of any other value there closes it. Bit 0 at offset 0xFB4 reads 1 while closed and 0 while open. Writes to 0xFB0 are accepted in either state.
- R3: While the lock is closed, writes to every offset other than 0xFB0 leave all register state and all outputs unchanged.
- R4: Bit 0 at offset 0x000 is the routing enable. While it is 0, every channel reads inactive and no output trigger can newly set. Outputs that are already set stay set.
- R5: The word at 0x020 + 4·N holds the channel mask of input N, one bit per channel in bits 3:0. Bits above the channel count read 0.
- R6: Channel C is active when routing is enabled and some high input has bit C set in its mask. Channel activity appears in bits 3:0 at offset 0x138, and the same value appears at 0x13C.
- R7: The word at 0x0A0 + 4·M holds the channel mask of output M. Output M goes high on the clock edge that follows a cycle in which a channel in its mask is active, and it stays high after that channel goes quiet.
- R8: An open-lock write to offset 0x010 clears, on the next edge, every output whose bit position in the write data is 1. Other outputs are unaffected.
- R9: If a clear and a new set reach the same output in the same cycle, the output stays high.
- R10: Offset 0x130 reads the current input lines in bits 7:0. Offset 0x134 reads the output triggers in bits 7:0.
- R11: Reads from any offset not named above return 0, and reads return register contents while the lock is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 8 | Input trigger lines, synchronous to clk |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| trig_out | output | 8 | Sticky output triggers |

## Verification
The assertions assume that the trigger inputs are already synchronous to the clock and are stable at each rising edge. They also assume that a bus write lasts exactly one cycle, with the address and data held for that cycle. The stimulus meets these assumptions by changing trig_in and all bus signals only on falling edges. Each write strobe is raised for a single period. A clear that coincides with a live trigger is created on purpose by holding the input steady across the write cycle.

// File: rtl/xtrig_pkg.sv
// Shared constants for the cross-trigger matrix: register offsets and the unlock key.
// Assumes a 12-bit byte address space with word-aligned registers.
package xtrig_pkg;
    localparam int          ADDR_W     = 12;
    localparam logic [11:0] OFF_CTRL   = 12'h000;
    localparam logic [11:0] OFF_ACK    = 12'h010;
    localparam logic [11:0] OFF_INMAP  = 12'h020;
    localparam logic [11:0] OFF_OUTMAP = 12'h0A0;
    localparam logic [11:0] OFF_ST_IN  = 12'h130;
    localparam logic [11:0] OFF_ST_OUT = 12'h134;
    localparam logic [11:0] OFF_ST_CHI = 12'h138;
    localparam logic [11:0] OFF_ST_CHO = 12'h13C;
    localparam logic [11:0] OFF_KEY    = 12'hFB0;
    localparam logic [11:0] OFF_LKSTAT = 12'hFB4;
    localparam logic [31:0] UNLOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/xtrig_lock.sv
// Key lock: writing the unlock key opens it, and writing any other value closes it.
// Assumes single-cycle write strobes. Reset leaves the lock closed.
module xtrig_lock
    import xtrig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              locked
);
    // Update the lock state on every write to the key word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b1;
        else if (wr_en && addr == OFF_KEY)
            locked <= (wdata != UNLOCK_KEY);
    end
endmodule

// File: rtl/xtrig_regs.sv
// Register file for the enable bit and the per-trigger channel masks,
// plus a one-cycle clear vector for the output latches.
// Assumes wr_ok is already gated by the lock.
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_ok,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [31:0]                    wdata,
    output logic                           enable,
    output logic [NUM_IN-1:0][NUM_CH-1:0]  in_map,
    output logic [NUM_OUT-1:0][NUM_CH-1:0] out_map,
    output logic [NUM_OUT-1:0]             ack_vec
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Global routing enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= 1'b0;
        else if (wr_ok && addr == OFF_CTRL)
            enable <= wdata[0];
    end

    // A clear request lasts for exactly the write cycle.
    assign ack_vec = (wr_ok && addr == OFF_ACK) ? wdata[NUM_OUT-1:0] : '0;

    for (genvar n = 0; n < NUM_IN; n++) begin : g_in
        // Channel mask of input n.
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_map[n] <= '0;
            else if (wr_ok && addr == ADDR_W'(OFF_INMAP + 4 * n))
                in_map[n] <= wdata[NUM_CH-1:0];
        end
    end

    for (genvar m = 0; m < NUM_OUT; m++) begin : g_out
        // Channel mask of output m.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_map[m] <= '0;
            else if (wr_ok && addr == ADDR_W'(OFF_OUTMAP + 4 * m))
                out_map[m] <= wdata[NUM_CH-1:0];
        end
    end
endmodule

// File: rtl/xtrig_route.sv
// Two-stage routing: inputs feed the channels, and the channels set the sticky output latches.
// Assumes trig_in is synchronous to clk. When a set and a clear arrive together, the set wins.
module xtrig_route #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [NUM_IN-1:0]              trig_in,
    input  logic [NUM_IN-1:0][NUM_CH-1:0]  in_map,
    input  logic [NUM_OUT-1:0][NUM_CH-1:0] out_map,
    input  logic [NUM_OUT-1:0]             ack_vec,
    output logic [NUM_CH-1:0]              ch_act,
    output logic [NUM_OUT-1:0]             trig_out
);
    logic [NUM_OUT-1:0] hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [NUM_IN-1:0] col;
        for (genvar n = 0; n < NUM_IN; n++) begin : g_col
            assign col[n] = in_map[n][c];
        end
        // Channel c is active when any high input maps onto it.
        assign ch_act[c] = enable && |(trig_in & col);
    end

    for (genvar m = 0; m < NUM_OUT; m++) begin : g_hit
        assign hit[m] = |(ch_act & out_map[m]);
    end

    // Sticky output latches: a new set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_out <= '0;
        else
            trig_out <= hit | (trig_out & ~ack_vec);
    end
endmodule

// File: rtl/xtrig_matrix.sv
// Top of the cross-trigger matrix: lock, register file, routing and the read multiplexer.
// Assumes single-cycle bus writes. Reads are combinational and are never gated by the lock.
module xtrig_matrix
    import xtrig_pkg::*;
#(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    parameter int NUM_CH  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  trig_in,
    input  logic [11:0]        bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_OUT-1:0] trig_out
);
    logic                           locked;
    logic                           enable;
    logic [NUM_IN-1:0][NUM_CH-1:0]  in_map;
    logic [NUM_OUT-1:0][NUM_CH-1:0] out_map;
    logic [NUM_OUT-1:0]             ack_vec;
    logic [NUM_CH-1:0]              ch_act;

    xtrig_lock u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .locked(locked)
    );

    xtrig_regs #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(bus_we && !locked), .addr(bus_addr),
        .wdata(bus_wdata), .enable(enable), .in_map(in_map),
        .out_map(out_map), .ack_vec(ack_vec)
    );

    xtrig_route #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CH(NUM_CH)) u_route (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_in(trig_in),
        .in_map(in_map), .out_map(out_map), .ack_vec(ack_vec),
        .ch_act(ch_act), .trig_out(trig_out)
    );

    // Read multiplexer: unknown offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL:   bus_rdata = {31'b0, enable};
            OFF_ST_IN:  bus_rdata = 32'(trig_in);
            OFF_ST_OUT: bus_rdata = 32'(trig_out);
            OFF_ST_CHI: bus_rdata = 32'(ch_act);
            OFF_ST_CHO: bus_rdata = 32'(ch_act);
            OFF_LKSTAT: bus_rdata = {31'b0, locked};
            default:    bus_rdata = '0;
        endcase
        for (int n = 0; n < NUM_IN; n++)
            if (bus_addr == ADDR_W'(OFF_INMAP + 4 * n))
                bus_rdata = 32'(in_map[n]);
        for (int m = 0; m < NUM_OUT; m++)
            if (bus_addr == ADDR_W'(OFF_OUTMAP + 4 * m))
                bus_rdata = 32'(out_map[m]);
    end
endmodule

// File: rtl/xtrig_matrix_chk.sv
// Property checker for the cross-trigger matrix, attached to the top through bind.
// Assumes single-cycle writes and triggers that are synchronous to clk.
module xtrig_matrix_chk
    import xtrig_pkg::*;
#(
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [11:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_OUT-1:0] trig_out,
    input logic               locked,
    input logic               enable
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (trig_out == '0 && locked && !enable));

    // R2
    key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_KEY && bus_wdata == UNLOCK_KEY) |=> !locked);

    // R2
    bad_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_KEY && bus_wdata != UNLOCK_KEY) |=> locked);

    // R3
    locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_we && bus_addr == OFF_CTRL) |=> $stable(enable));

    // R4
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((trig_out & ~$past(trig_out)) == '0));

    // R8
    clear_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(trig_out) & ~trig_out)) |->
            $past(bus_we && bus_addr == OFF_ACK && !locked));
endmodule

bind xtrig_matrix xtrig_matrix_chk #(.NUM_OUT(NUM_OUT)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .trig_out(trig_out), .locked(locked), .enable(enable)
);

// File: tb/xtrig_matrix_tb_top.sv
// Self-checking bench: lock and register sweeps, then a sweep over all 256 input patterns
// with expected channel and output values computed from the mapping masks.
module xtrig_matrix_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  trig_out;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xtrig_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_out(trig_out)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [3:0] imap(input int n);
        return 4'((n * 7 + 3) % 16);
    endfunction
    function automatic logic [3:0] omap(input int m);
        return 4'((m * 5 + 1) % 16);
    endfunction
    function automatic logic [3:0] ch_of(input logic [7:0] p);
        logic [3:0] c = '0;
        for (int n = 0; n < 8; n++) if (p[n]) c |= imap(n);
        return c;
    endfunction
    function automatic logic [7:0] hit_of(input logic [3:0] c);
        logic [7:0] h = '0;
        for (int m = 0; m < 8; m++) if (|(c & omap(m))) h[m] = 1'b1;
        return h;
    endfunction

    initial begin
        #2_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_out;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'hFB4, v); check("R1 lock", v, 32'd1);
        rd(12'h000, v); check("R1 ctrl", v, 32'd0);
        for (int n = 0; n < 8; n++) begin
            rd(12'(12'h020 + 4 * n), v); check("R1 inmap", v, 0);
            rd(12'(12'h0A0 + 4 * n), v); check("R1 outmap", v, 0);
        end
        check("R1 trig_out", 32'(trig_out), 0);
        // R3 writes ignored while locked
        wr(12'h000, 1); wr(12'h020, 32'hF); wr(12'h0A0, 32'hF);
        rd(12'h000, v); check("R3 ctrl", v, 0);
        rd(12'h020, v); check("R3 inmap", v, 0);
        rd(12'h0A0, v); check("R3 outmap", v, 0);
        // R2 unlock with key, lock with wrong key
        wr(12'hFB0, 32'hC5ACCE54);
        rd(12'hFB4, v); check("R2 wrong key", v, 1);
        wr(12'hFB0, 32'hC5ACCE55);
        rd(12'hFB4, v); check("R2 unlocked", v, 0);
        // R5 and R7 mapping registers with upper bits dropped
        for (int n = 0; n < 8; n++) begin
            wr(12'(12'h020 + 4 * n), 32'hFFFF_FFF0 | 32'(imap(n)));
            wr(12'(12'h0A0 + 4 * n), 32'(omap(n)));
        end
        for (int n = 0; n < 8; n++) begin
            rd(12'(12'h020 + 4 * n), v); check("R5 inmap rb", v, 32'(imap(n)));
            rd(12'(12'h0A0 + 4 * n), v); check("R7 outmap rb", v, 32'(omap(n)));
        end
        // R4 disabled: no channel, no output
        trig_in = 8'hFF;
        @(negedge clk); @(negedge clk);
        rd(12'h138, v); check("R4 channels off", v, 0);
        check("R4 no output", 32'(trig_out), 0);
        trig_in = 8'h00;
        wr(12'h000, 1);
        rd(12'h000, v); check("R4 enabled", v, 1);
        // R6 R7 R10 sweep of every input pattern with sticky accumulation
        exp_out = '0;
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            trig_in = 8'(p);
            rd(12'h138, v); check("R6 chan in", v, 32'(ch_of(8'(p))));
            rd(12'h13C, v); check("R6 chan out", v, 32'(ch_of(8'(p))));
            rd(12'h130, v); check("R10 in status", v, 32'(p));
            @(negedge clk);
            exp_out |= hit_of(ch_of(8'(p)));
            check("R7 sticky", 32'(trig_out), 32'(exp_out));
            rd(12'h134, v); check("R10 out status", v, 32'(exp_out));
        end
        trig_in = 8'h00;
        // R8 selective clear
        wr(12'h010, 32'h0000_0005);
        check("R8 partial clear", 32'(trig_out), 32'(exp_out & 8'hFA));
        wr(12'h010, 32'hFF);
        check("R8 full clear", 32'(trig_out), 0);
        // R9 clear collides with live trigger on output 0 (input 1 -> ch 1,3; output 0 <- ch 0)
        trig_in = 8'h01;                 // input 0 -> ch 0,1 -> sets output 0
        @(negedge clk);
        check("R9 set", 32'(trig_out[0]), 1);
        wr(12'h010, 32'h1);
        check("R9 set wins", 32'(trig_out[0]), 1);
        trig_in = 8'h00;
        wr(12'h010, 32'h1);
        check("R8 clear bit0", 32'(trig_out[0]), 0);
        // R11 unmapped reads and reads while locked
        rd(12'h004, v); check("R11 unmapped", v, 0);
        rd(12'h800, v); check("R11 unmapped hi", v, 0);
        wr(12'hFB0, 32'h0);
        rd(12'hFB4, v); check("R2 relock", v, 1);
        rd(12'h024, v); check("R11 read locked", v, 32'(imap(1)));
        // R3 clear ignored while locked
        trig_in = 8'h01;
        @(negedge clk);
        trig_in = 8'h00;
        wr(12'h010, 32'hFF);
        check("R3 clear ignored", 32'(trig_out[0]), 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule